// File: doc/BRIEF.md
# Write-Combining Store Merge Buffer with Commit Ordering

This block gathers uncached processor stores into one 8-lane byte buffer and sends the merged result to the system bus as a single write. Each store arrives with an address, a byte-lane enable mask, 64 bits of data and a combinable flag. The combinable flag comes from a memory-type lookup outside the block. A store may join the buffer only when that flag is set and the store falls in the same 8-byte-aligned block. Any other store first pushes the buffered data out to the bus.

The block also decides when a store that hits a modified or exclusive cache line may write into the cache. Normally that commit waits for three conditions. The active-low external write-buffer-empty input must be low, the merge buffer must be empty and the outgoing bus slot must be drained. A pending commit request forces the buffer to flush. System logic can therefore hold the empty input high until its own external write completes, and a later cache write cannot overtake it. Setting the global ordering-disable input turns all of this off. Commits then pass at once and no flush is forced.

Top module: `wcm_top`

## Requirements
- R1: A combinable store to the block already held is merged. The held mask becomes the OR of the old mask and the store's mask. The store's enabled lanes replace the old bytes, with lane i at data bits [8i+7:8i] and mask bit i.
- R2: A bus write presents the aligned block address (low 3 bits zero), the 64 data bits and the accumulated 8-bit mask. All of them stay stable while bus_valid_o is high and bus_ready_i is low.
- R3: A combinable store to a different block is not accepted until the held data has been moved to the bus slot. It then starts a fresh buffer.
- R4: A non-combinable store first flushes any held data. It is then issued alone as its own bus write, with its own address and mask.
- R5: With ord_dis_i low, commit_ok_o is high only when commit_req_i is high, wbe_n_i is low (low means the external buffer is empty), the merge buffer is empty and no bus write is pending.
- R6: With ord_dis_i high, commit_ok_o equals commit_req_i whatever wbe_n_i, the buffer and the bus slot hold. A commit request then forces no flush.
- R7: With ord_dis_i low, a commit request while data is held moves the data to the bus slot as soon as the slot is free.
- R8: st_ready_o is low while a required flush waits for a free bus slot, and in any cycle in which a commit-forced flush is pending. A store offered in such a cycle is not merged.
- R9: After reset the buffer is empty, bus_valid_o is low and st_ready_o is high for a combinable store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Store offered |
| st_ready_o | output | 1 | Store accepted this cycle |
| st_addr_i | input | 32 | Store byte address |
| st_be_i | input | 8 | Store byte-lane enables |
| st_data_i | input | 64 | Store data, lane i at bits [8i+7:8i] |
| st_wc_i | input | 1 | Store may be combined |
| commit_req_i | input | 1 | Cache-hit store asks to commit to a modified/exclusive line |
| commit_ok_o | output | 1 | Commit permitted this cycle |
| wbe_n_i | input | 1 | External write buffer empty, active low |
| ord_dis_i | input | 1 | Global ordering disable |
| bus_valid_o | output | 1 | Bus write pending |
| bus_ready_i | input | 1 | Bus accepts the write |
| bus_addr_o | output | 32 | Aligned block address |
| bus_data_o | output | 64 | Merged data |
| bus_be_o | output | 8 | Merged byte mask |

## Verification
Two functions can meet in one cycle: a combinable store to the held block, which would merge, and a commit request that forces the same buffer out. The bench holds a block, then raises commit_req_i and offers such a store together. It expects st_ready_o low in that cycle. It then expects the bus slot to carry only the old mask, and the store to be accepted one cycle later into a fresh buffer.

// File: rtl/wcm_pkg.sv
package wcm_pkg;
  localparam int unsigned WCM_ADDR_W = 32;
  localparam int unsigned WCM_LANES  = 8;

  typedef enum logic [1:0] {
    FL_NONE,
    FL_STORE,
    FL_COMMIT
  } flush_cause_e;
endpackage

// File: rtl/wcm_merge_buf.sv
module wcm_merge_buf #(
  parameter int unsigned AddrW = 32,
  parameter int unsigned Lanes = 8,
  localparam int unsigned OffW  = $clog2(Lanes),
  localparam int unsigned BlkW  = AddrW - OffW,
  localparam int unsigned DataW = 8 * Lanes
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             flush_i,
  input  logic [BlkW-1:0]  blk_i,
  input  logic [Lanes-1:0] be_i,
  input  logic [DataW-1:0] data_i,
  output logic             valid_o,
  output logic [BlkW-1:0]  blk_o,
  output logic [Lanes-1:0] be_o,
  output logic [DataW-1:0] data_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      blk_o   <= '0;
      be_o    <= '0;
    end else if (flush_i) begin
      valid_o <= 1'b0;
      be_o    <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      blk_o   <= blk_i;
      be_o    <= valid_o ? (be_o | be_i) : be_i;
    end
  end

  for (genvar g = 0; g < Lanes; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_o[8*g +: 8] <= '0;
      end else if (load_i && be_i[g]) begin
        data_o[8*g +: 8] <= data_i[8*g +: 8];
      end
    end
  end

  // Merging never drops a lane already held
  p_be_grow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && load_i && !flush_i |=> (be_o & $past(be_o)) == $past(be_o));

  p_flush_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !valid_o);

endmodule

// File: rtl/wcm_bus_slot.sv
module wcm_bus_slot #(
  parameter int unsigned AddrW = 32,
  parameter int unsigned Lanes = 8,
  localparam int unsigned DataW = 8 * Lanes
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [AddrW-1:0] addr_i,
  input  logic [Lanes-1:0] be_i,
  input  logic [DataW-1:0] data_i,
  input  logic             ready_i,
  output logic             free_o,
  output logic             valid_o,
  output logic [AddrW-1:0] addr_o,
  output logic [Lanes-1:0] be_o,
  output logic [DataW-1:0] data_o
);

  assign free_o = !valid_o || ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      be_o    <= '0;
      data_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      addr_o  <= addr_i;
      be_o    <= be_i;
      data_o  <= data_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  p_bus_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(addr_o) && $stable(be_o) && $stable(data_o));

  p_no_overwrite_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !valid_o || ready_i);

endmodule

// File: rtl/wcm_order_ctl.sv
module wcm_order_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic commit_req_i,
  input  logic ord_dis_i,
  input  logic wbe_n_i,
  input  logic buf_valid_i,
  input  logic bus_pend_i,
  output logic commit_ok_o,
  output logic flush_req_o
);

  logic drained;
  assign drained     = !wbe_n_i && !buf_valid_i && !bus_pend_i;
  assign commit_ok_o = commit_req_i && (ord_dis_i || drained);
  assign flush_req_o = commit_req_i && !ord_dis_i && buf_valid_i;

  p_dis_no_flush_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_req_i && ord_dis_i |-> commit_ok_o && !flush_req_o);

  p_flush_blocks_commit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_req_o |-> !commit_ok_o);

endmodule

// File: rtl/wcm_top.sv
module wcm_top
  import wcm_pkg::*;
#(
  parameter int unsigned AddrW = WCM_ADDR_W,
  parameter int unsigned Lanes = WCM_LANES,
  localparam int unsigned OffW  = $clog2(Lanes),
  localparam int unsigned BlkW  = AddrW - OffW,
  localparam int unsigned DataW = 8 * Lanes
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             st_valid_i,
  output logic             st_ready_o,
  input  logic [AddrW-1:0] st_addr_i,
  input  logic [Lanes-1:0] st_be_i,
  input  logic [DataW-1:0] st_data_i,
  input  logic             st_wc_i,
  input  logic             commit_req_i,
  output logic             commit_ok_o,
  input  logic             wbe_n_i,
  input  logic             ord_dis_i,
  output logic             bus_valid_o,
  input  logic             bus_ready_i,
  output logic [AddrW-1:0] bus_addr_o,
  output logic [DataW-1:0] bus_data_o,
  output logic [Lanes-1:0] bus_be_o
);

  logic             buf_v;
  logic [BlkW-1:0]  buf_blk;
  logic [Lanes-1:0] buf_be;
  logic [DataW-1:0] buf_data;
  logic [BlkW-1:0]  st_blk;
  logic             same_blk;
  logic             slot_free;
  logic             cflush_req;
  logic             st_flush_req;
  flush_cause_e     cause;
  logic             do_flush;
  logic             do_merge;
  logic             do_direct;
  logic             slot_load;
  logic [AddrW-1:0] slot_addr;
  logic [Lanes-1:0] slot_be;
  logic [DataW-1:0] slot_data;

  assign st_blk   = st_addr_i[AddrW-1:OffW];
  assign same_blk = buf_v && (buf_blk == st_blk);

  assign st_flush_req = st_valid_i && buf_v && (!st_wc_i || !same_blk);

  always_comb begin
    if (cflush_req)        cause = FL_COMMIT;
    else if (st_flush_req) cause = FL_STORE;
    else                   cause = FL_NONE;
  end

  assign do_flush = (cause != FL_NONE) && slot_free;

  // Commit-forced flush stalls stores; wc joins empty or same block; non-wc needs empty buffer and free slot
  always_comb begin
    if (cflush_req)   st_ready_o = 1'b0;
    else if (st_wc_i) st_ready_o = !buf_v || same_blk;
    else              st_ready_o = !buf_v && slot_free;
  end

  assign do_merge  = st_valid_i && st_ready_o && st_wc_i;
  assign do_direct = st_valid_i && st_ready_o && !st_wc_i;
  assign slot_load = do_flush || do_direct;

  always_comb begin
    if (do_flush) begin
      slot_addr = {buf_blk, {OffW{1'b0}}};
      slot_be   = buf_be;
      slot_data = buf_data;
    end else begin
      slot_addr = {st_blk, {OffW{1'b0}}};
      slot_be   = st_be_i;
      slot_data = st_data_i;
    end
  end

  wcm_merge_buf #(.AddrW(AddrW), .Lanes(Lanes)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (do_merge),
    .flush_i (do_flush),
    .blk_i   (st_blk),
    .be_i    (st_be_i),
    .data_i  (st_data_i),
    .valid_o (buf_v),
    .blk_o   (buf_blk),
    .be_o    (buf_be),
    .data_o  (buf_data)
  );

  wcm_bus_slot #(.AddrW(AddrW), .Lanes(Lanes)) u_slot (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (slot_load),
    .addr_i  (slot_addr),
    .be_i    (slot_be),
    .data_i  (slot_data),
    .ready_i (bus_ready_i),
    .free_o  (slot_free),
    .valid_o (bus_valid_o),
    .addr_o  (bus_addr_o),
    .be_o    (bus_be_o),
    .data_o  (bus_data_o)
  );

  wcm_order_ctl u_ord (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .commit_req_i (commit_req_i),
    .ord_dis_i    (ord_dis_i),
    .wbe_n_i      (wbe_n_i),
    .buf_valid_i  (buf_v),
    .bus_pend_i   (bus_valid_o),
    .commit_ok_o  (commit_ok_o),
    .flush_req_o  (cflush_req)
  );

  p_merge_flush_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({do_merge, do_flush, do_direct}));

  p_commit_order_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_ok_o && !ord_dis_i |-> !bus_valid_o && !wbe_n_i);

  p_cflush_moves_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cflush_req && slot_free |=> bus_valid_o && !buf_v);

  p_stall_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_valid_i && buf_v && !st_wc_i |-> !st_ready_o);

  p_new_block_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_merge && !buf_v |=> buf_v && bus_valid_o == $past(bus_valid_o && !bus_ready_i));

endmodule

// File: tb/wcm_top_tb.sv
module wcm_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_valid = 1'b0;
  logic        st_ready;
  logic [31:0] st_addr = '0;
  logic [7:0]  st_be = '0;
  logic [63:0] st_data = '0;
  logic        st_wc = 1'b1;
  logic        commit_req = 1'b0;
  logic        commit_ok;
  logic        wbe_n = 1'b0;
  logic        ord_dis = 1'b0;
  logic        bus_valid;
  logic        bus_ready = 1'b0;
  logic [31:0] bus_addr;
  logic [63:0] bus_data;
  logic [7:0]  bus_be;

  int n_run  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  wcm_top u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .st_valid_i(st_valid), .st_ready_o(st_ready), .st_addr_i(st_addr),
    .st_be_i(st_be), .st_data_i(st_data), .st_wc_i(st_wc),
    .commit_req_i(commit_req), .commit_ok_o(commit_ok),
    .wbe_n_i(wbe_n), .ord_dis_i(ord_dis),
    .bus_valid_o(bus_valid), .bus_ready_i(bus_ready),
    .bus_addr_o(bus_addr), .bus_data_o(bus_data), .bus_be_o(bus_be)
  );

  // {commit_req, ord_dis, wbe_n, expected commit_ok} with empty buffer and idle bus
  localparam logic [3:0] VEC [8] = '{
    4'b0000, 4'b0010, 4'b0100, 4'b0110,
    4'b1001, 4'b1010, 4'b1101, 4'b1111
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put_store(input logic [31:0] a, input logic [7:0] be,
                           input logic [63:0] d, input logic wc);
    st_valid = 1'b1; st_addr = a; st_be = be; st_data = d; st_wc = wc;
    #1;
    for (int i = 0; i < 20 && !st_ready; i++) begin
      step(); #1;
    end
    step();
    st_valid = 1'b0;
  endtask

  task automatic drain();
    bus_ready = 1'b1;
    step();
    bus_ready = 1'b0;
  endtask

  initial begin
    #(20ns * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R9 bus idle", bus_valid, 0);
    chk("R9 ready", st_ready, 1);

    for (int k = 0; k < 8; k++) begin
      commit_req = VEC[k][3]; ord_dis = VEC[k][2]; wbe_n = VEC[k][1];
      #1;
      chk(VEC[k][2] ? "R6 commit table" : "R5 commit table", commit_ok, VEC[k][0]);
      step();
    end
    commit_req = 0; ord_dis = 0; wbe_n = 0;

    // R1/R2/R3: merge then new block
    put_store(32'h100, 8'h01, 64'h00000000_000000AA, 1);
    put_store(32'h104, 8'h20, 64'h00005500_00000000, 1);
    put_store(32'h103, 8'h01, 64'h00000000_000000BB, 1);
    chk("R1 no bus yet", bus_valid, 0);
    st_valid = 1; st_addr = 32'h208; st_be = 8'h03; st_data = 64'h2211; st_wc = 1;
    #1;
    chk("R3 stall on new block", st_ready, 0);
    step(); #1;
    chk("R3 ready after flush", st_ready, 1);
    step();
    st_valid = 0;
    chk("R2 bus valid", bus_valid, 1);
    chk("R2 aligned addr", bus_addr, 32'h100);
    chk("R1 or mask", bus_be, 8'h21);
    chk("R1 lane0 newest", bus_data[7:0], 8'hBB);
    chk("R1 lane5", bus_data[47:40], 8'h55);
    step();
    chk("R2 held addr", bus_addr, 32'h100);
    chk("R2 held mask", bus_be, 8'h21);
    drain();
    chk("R2 released", bus_valid, 0);

    // R4/R8: non-combinable store behind held block 0x208
    st_valid = 1; st_addr = 32'h305; st_be = 8'h0F; st_data = 64'hDDCCBBAA; st_wc = 0;
    #1;
    chk("R4 stall for flush", st_ready, 0);
    step(); #1;
    chk("R3 flushed addr", bus_addr, 32'h208);
    chk("R3 flushed mask", bus_be, 8'h03);
    chk("R8 stall slot busy", st_ready, 0);
    bus_ready = 1;
    #1;
    chk("R4 ready with slot free", st_ready, 1);
    step();
    st_valid = 0; bus_ready = 0;
    chk("R4 alone addr", bus_addr, 32'h300);
    chk("R4 alone mask", bus_be, 8'h0F);
    chk("R4 alone data", bus_data[31:0], 32'hDDCCBBAA);
    drain();

    // R7/R5: commit forces flush
    put_store(32'h407, 8'h80, 64'h77000000_00000000, 1);
    commit_req = 1; wbe_n = 0;
    #1;
    chk("R5 blocked by buffer", commit_ok, 0);
    step(); #1;
    chk("R7 flushed", bus_valid, 1);
    chk("R7 flushed addr", bus_addr, 32'h400);
    chk("R5 blocked by bus", commit_ok, 0);
    drain(); #1;
    chk("R5 granted", commit_ok, 1);
    wbe_n = 1; #1;
    chk("R5 wbe high blocks", commit_ok, 0);
    commit_req = 0; wbe_n = 0;

    // R6: disable bypasses ordering
    put_store(32'h500, 8'h01, 64'h11, 1);
    ord_dis = 1; wbe_n = 1; commit_req = 1;
    #1;
    chk("R6 granted", commit_ok, 1);
    step();
    chk("R6 no flush", bus_valid, 0);
    commit_req = 0; ord_dis = 0; wbe_n = 0;

    // R8: commit flush and mergeable store in same cycle
    commit_req = 1;
    st_valid = 1; st_addr = 32'h501; st_be = 8'h02; st_data = 64'h2200; st_wc = 1;
    #1;
    chk("R8 stall on commit flush", st_ready, 0);
    step();
    commit_req = 0;
    chk("R8 old mask only", bus_be, 8'h01);
    #1;
    chk("R8 ready after", st_ready, 1);
    step();
    st_valid = 0;
    drain();
    commit_req = 1; #1;
    step();
    commit_req = 0;
    chk("R8 store kept separate", bus_be, 8'h02);
    drain();

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule